// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks through the column addresses of one SDRAM burst. A controller pulses `start` together with the first column, the read/write direction and the programmed mode word, and on the following cycles the block presents one column per cycle. A valid strobe marks each beat and a last flag marks the final one. The mode word supplies the burst length, the ordering and the single-location write option. The same word is decoded in parallel so that the controller can see at once whether it holds a reserved or illegal setting.

Two orderings are produced. The sequential order counts up from the start offset and wraps inside the aligned block of burst-length columns. The interleaved order gives the start offset XOR the beat index. When single-location writes are enabled, any write burst is one beat long whatever length is programmed, and reads keep the programmed length. A new `start` during a burst cuts it short and begins again at the new column. `abort` ends a burst without starting another.

Top module: `burst_colgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `col_valid` and `col_last` are 0 in the following cycle, and both stay 0 until a burst is started.
- R2: A `start` sampled with `mode_err` = 0 makes `col_valid` 1 in the next cycle, with `col` equal to the sampled `start_col`.
- R3: The burst length comes from `mode_a[2:0]`: 000 = 1, 001 = 2, 010 = 4, 011 = 8 beats. There is one beat per cycle and `col_last` is 1 on the final beat only. In the cycle after the final beat `col_valid` is 0, unless a new burst starts.
- R4: With `mode_a[3]` = 0 (sequential), beat i carries column (start_col with its low log2(BL) bits replaced by (start offset + i) mod BL).
- R5: With `mode_a[3]` = 1 (interleaved), beat i carries start_col with its low log2(BL) bits replaced by (start offset XOR i).
- R6: With `mode_a[9]` = 1, a burst started with `is_write` = 1 lasts exactly one beat (`col_last` 1 on its first beat). Read bursts and writes with `mode_a[9]` = 0 keep the programmed length.
- R7: `mode_err` is a combinational flag that is 1 when any of these holds: `mode_a[2]` = 1 (reserved length), `mode_a[6:4]` is neither 010 (latency 2) nor 011 (latency 3), any of `mode_a[7]`, `mode_a[8]`, `mode_a[11]` is 1, or `mode_ba` is nonzero.
- R8: A `start` sampled while `mode_err` = 1 is ignored. With no burst running, `col_valid` stays 0.
- R9: A legal `start` during a running burst ends that burst. The next cycle shows beat 0 of the new burst at the new `start_col`, and `start` takes priority over `abort` in the same cycle.
- R10: `abort` sampled without `start` makes `col_valid` 0 in the next cycle.
- R11: During a burst, column bits above bit 2 do not change from one beat to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst at `start_col` |
| abort | input | 1 | End the running burst |
| is_write | input | 1 | The burst being started is a write |
| start_col | input | COL_W | First column of the burst |
| mode_a | input | 12 | Programmed mode word (address bits) |
| mode_ba | input | 2 | Bank-select bits of the mode word, must be 0 |
| col | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | The current beat is the final one |
| mode_err | output | 1 | The mode inputs hold a reserved or illegal setting |

## Verification
Full bursts at every length are run in both orderings from one unaligned start column, so an ordering fault and a length fault each show up as a wrong column or a misplaced last flag. The single-write option is tried with a write, with a read and with the option off, which tells forced length from programmed length. Each reserved field is set alone to show which term of the error flag is missing. A restart with abort raised in the same cycle, and a plain abort, separate the two ways a burst can end early.

// File: rtl/burst_pkg.sv
// Shared types and constants for the burst column generator.
// Assumes the largest burst is 8 beats, so a beat index needs 3 bits.
package burst_pkg;
    localparam int MAX_BURST = 8;
    localparam int BEAT_W    = $clog2(MAX_BURST);
    localparam int LG_W      = 2;

    typedef struct packed {
        logic [LG_W-1:0] len_lg;     // log2 of programmed length
        logic            interleave; // 1 = XOR order
        logic            single_wr;  // writes forced to one beat
        logic            err;        // illegal or reserved setting
    } mode_t;
endpackage

// File: rtl/burst_mode_decode.sv
// Decodes the mode word into burst length, ordering and write option,
// and flags reserved length, reserved latency and nonzero must-be-zero bits.
// Purely combinational; assumes the mode inputs are stable when start is sampled.
module burst_mode_decode
    import burst_pkg::*;
(
    input  logic [11:0] mode_a,
    input  logic [1:0]  mode_ba,
    output mode_t       mode
);
    logic [2:0] lat_code;
    logic       err_len;
    logic       err_lat;
    logic       err_zero;
    logic       unused_bit10;

    // Field split and legality terms.
    always_comb begin
        lat_code = mode_a[6:4];
        err_len  = mode_a[2];
        err_lat  = !((lat_code == 3'b010) || (lat_code == 3'b011));
        err_zero = mode_a[7] | mode_a[8] | mode_a[11] | (|mode_ba);
    end

    // Decoded mode record.
    always_comb begin
        mode.len_lg     = mode_a[1:0];
        mode.interleave = mode_a[3];
        mode.single_wr  = mode_a[9];
        mode.err        = err_len | err_lat | err_zero;
    end

    assign unused_bit10 = mode_a[10];
endmodule

// File: rtl/burst_beat_ctr.sv
// Burst sequencer: captures the start column and effective length on a legal
// start, then advances one beat per cycle until the last beat or an abort.
// Assumes start has priority over abort; synchronous active-low reset.
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    input  mode_t             mode,
    output logic              active,
    output logic              last,
    output logic [BEAT_W-1:0] beat,
    output logic [LG_W-1:0]   len_lg_q,
    output logic              inter_q,
    output logic [COL_W-1:0]  base_q
);
    logic            accept;
    logic [LG_W-1:0] eff_lg;
    logic [BEAT_W-1:0] final_beat;

    // Accept decision and effective length for the burst being started.
    always_comb begin
        accept = start && !mode.err;
        eff_lg = (is_write && mode.single_wr) ? '0 : mode.len_lg;
    end

    // Final beat index for the running burst.
    always_comb begin
        final_beat = BEAT_W'((1 << len_lg_q) - 1);
        last       = active && (beat == final_beat);
    end

    // Burst state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat     <= '0;
            len_lg_q <= '0;
            inter_q  <= 1'b0;
            base_q   <= '0;
        end else if (accept) begin
            active   <= 1'b1;
            beat     <= '0;
            len_lg_q <= eff_lg;
            inter_q  <= mode.interleave;
            base_q   <= start_col;
        end else if (abort || last) begin
            active   <= 1'b0;
            beat     <= '0;
        end else if (active) begin
            beat     <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_col_calc.sv
// Forms the column of a beat: the bits above the burst block come from the
// start column, the low bits from a sequential sum or an XOR with the beat.
// Combinational; assumes COL_W is larger than the beat index width.
module burst_col_calc
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    input  logic [LG_W-1:0]   len_lg,
    input  logic              interleave,
    output logic [COL_W-1:0]  col
);
    logic [BEAT_W-1:0] mask;
    logic [BEAT_W-1:0] low_in;
    logic [BEAT_W-1:0] ofs;
    logic [BEAT_W-1:0] low_out;

    // Block mask and start offset.
    always_comb begin
        mask   = BEAT_W'((1 << len_lg) - 1);
        low_in = base[BEAT_W-1:0];
    end

    // Offset inside the block for the selected ordering.
    generate
        if (BEAT_W > 0) begin : g_order
            always_comb begin
                if (interleave) ofs = low_in ^ beat;
                else            ofs = low_in + beat;
            end
        end
    endgenerate

    // Merge: keep bits outside the block, replace bits inside it.
    always_comb begin
        low_out = (low_in & ~mask) | (ofs & mask);
        col     = {base[COL_W-1:BEAT_W], low_out};
    end
endmodule

// File: rtl/burst_colgen.sv
// Top of the burst column generator: decodes the mode word, sequences the
// beats and computes each column. Outputs are driven from registered state.
// Assumes one beat per clock and synchronous active-low reset.
module burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             is_write,
    input  logic [COL_W-1:0] start_col,
    input  logic [11:0]      mode_a,
    input  logic [1:0]       mode_ba,
    output logic [COL_W-1:0] col,
    output logic             col_valid,
    output logic             col_last,
    output logic             mode_err
);
    mode_t             mode;
    logic              active;
    logic              last;
    logic [BEAT_W-1:0] beat;
    logic [LG_W-1:0]   len_lg_q;
    logic              inter_q;
    logic [COL_W-1:0]  base_q;
    logic [COL_W-1:0]  col_raw;

    burst_mode_decode u_dec (
        .mode_a  (mode_a),
        .mode_ba (mode_ba),
        .mode    (mode)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .is_write  (is_write),
        .start_col (start_col),
        .mode      (mode),
        .active    (active),
        .last      (last),
        .beat      (beat),
        .len_lg_q  (len_lg_q),
        .inter_q   (inter_q),
        .base_q    (base_q)
    );

    burst_col_calc #(.COL_W(COL_W)) u_calc (
        .base       (base_q),
        .beat       (beat),
        .len_lg     (len_lg_q),
        .interleave (inter_q),
        .col        (col_raw)
    );

    // Output drive.
    always_comb begin
        col       = col_raw;
        col_valid = active;
        col_last  = last;
        mode_err  = mode.err;
    end
endmodule

// File: rtl/burst_colgen_chk.sv
// Checker for the burst column generator, observing the top-level ports only.
// Attached to every instance of the top by the bind below.
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic             is_write,
    input logic [COL_W-1:0] start_col,
    input logic [11:0]      mode_a,
    input logic [1:0]       mode_ba,
    input logic [COL_W-1:0] col,
    input logic             col_valid,
    input logic             col_last,
    input logic             mode_err
);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!col_valid && !col_last));

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode_err) |=> (col_valid && col == $past(start_col)));

    a_r3_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && !start) |=> !col_valid);

    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode_err && is_write && mode_a[9]) |=> col_last);

    a_r8_err_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode_err && !col_valid) |=> !col_valid);

    a_r10_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start) |=> !col_valid);

    a_r11_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !start && !abort)
        |=> (col_valid && col[COL_W-1:3] == $past(col[COL_W-1:3])));

    a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    logic unused_chk;
    assign unused_chk = ^{mode_ba};
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_colgen.sv
module tb_burst_colgen;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic             is_write = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [11:0]      mode_a = 12'h020;
    logic [1:0]       mode_ba = 2'b00;
    logic [COL_W-1:0] col;
    logic             col_valid;
    logic             col_last;
    logic             mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .is_write(is_write), .start_col(start_col), .mode_a(mode_a),
        .mode_ba(mode_ba), .col(col), .col_valid(col_valid),
        .col_last(col_last), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Mode word: [9] single write, [6:4] latency, [3] order, [2:0] length.
    function automatic logic [11:0] mk_mode(input int code, input bit inter, input int lat, input bit sw);
        logic [11:0] m;
        m = '0;
        m[2:0] = code[2:0];
        m[3]   = inter;
        m[6:4] = lat[2:0];
        m[9]   = sw;
        return m;
    endfunction

    // Column of beat i from the ordering rules.
    function automatic int exp_col(input int base, input int len, input bit inter, input int i);
        int off, blk;
        off = base % len;
        blk = base - off;
        if (inter) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    // Starts a burst at the next edge; returns after that edge, at a falling edge.
    task automatic kick(input int base, input logic [11:0] m, input bit wr, input bit ab);
        @(negedge clk);
        start_col = base[COL_W-1:0];
        mode_a = m;
        is_write = wr;
        start = 1'b1;
        abort = ab;
        @(negedge clk);
        start = 1'b0;
        abort = 1'b0;
    endtask

    // Checks beats first..len-1 of a burst; called at beat `first`.
    task automatic follow(input string req, input int base, input int len, input bit inter, input int first);
        for (int i = first; i < len; i++) begin
            if (i != first) @(negedge clk);
            chk(col_valid, req, col_valid, 1);
            chk(col == exp_col(base, len, inter, i), req, col, exp_col(base, len, inter, i));
            chk(col_last == (i == len - 1), req, col_last, (i == len - 1));
        end
        @(negedge clk);
        chk(!col_valid, "R3", col_valid, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!col_valid && !col_last, "R1", {col_valid, col_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!col_valid, "R1", col_valid, 0);
    endtask

    // R3 R4 R5 R2: every length in both orders from an unaligned column.
    task automatic t_lengths;
        for (int code = 0; code < 4; code++) begin
            for (int inter = 0; inter < 2; inter++) begin
                kick(8'h35, mk_mode(code, inter[0], 2, 1'b0), 1'b0, 1'b0);
                chk(col == 8'h35, "R2", col, 8'h35);
                follow(inter ? "R5" : "R4", 8'h35, 1 << code, inter[0], 0);
            end
        end
        kick(8'h4E, mk_mode(2, 1'b0, 3, 1'b0), 1'b0, 1'b0);
        follow("R4", 8'h4E, 4, 1'b0, 0);
        kick(8'hCB, mk_mode(3, 1'b1, 3, 1'b0), 1'b0, 1'b0);
        follow("R5", 8'hCB, 8, 1'b1, 0);
    endtask

    task automatic t_single_write;
        kick(8'h12, mk_mode(3, 1'b0, 2, 1'b1), 1'b1, 1'b0);
        chk(col_valid && col_last && col == 8'h12, "R6", {col_valid, col_last}, 3);
        @(negedge clk);
        chk(!col_valid, "R6", col_valid, 0);
        kick(8'h12, mk_mode(3, 1'b0, 2, 1'b1), 1'b0, 1'b0);
        follow("R6", 8'h12, 8, 1'b0, 0);
        kick(8'h12, mk_mode(2, 1'b1, 2, 1'b0), 1'b1, 1'b0);
        follow("R6", 8'h12, 4, 1'b1, 0);
    endtask

    task automatic t_mode_err;
        mode_ba = 2'b00;
        mode_a = mk_mode(2, 1'b0, 2, 1'b0); #1 chk(!mode_err, "R7", mode_err, 0);
        mode_a = mk_mode(3, 1'b1, 3, 1'b1); #1 chk(!mode_err, "R7", mode_err, 0);
        mode_a = mk_mode(4, 1'b0, 2, 1'b0); #1 chk(mode_err, "R7", mode_err, 1);
        mode_a = mk_mode(7, 1'b0, 2, 1'b0); #1 chk(mode_err, "R7", mode_err, 1);
        mode_a = mk_mode(1, 1'b0, 1, 1'b0); #1 chk(mode_err, "R7", mode_err, 1);
        mode_a = mk_mode(1, 1'b0, 4, 1'b0); #1 chk(mode_err, "R7", mode_err, 1);
        for (int b = 7; b < 12; b++) begin
            if (b == 9 || b == 10) continue;
            mode_a = mk_mode(1, 1'b0, 2, 1'b0);
            mode_a[b] = 1'b1;
            #1 chk(mode_err, "R7", b, 1);
        end
        mode_a = mk_mode(1, 1'b0, 2, 1'b0);
        mode_ba = 2'b01; #1 chk(mode_err, "R7", mode_ba, 1);
        mode_ba = 2'b10; #1 chk(mode_err, "R7", mode_ba, 1);
        kick(8'h20, mk_mode(1, 1'b0, 2, 1'b0), 1'b0, 1'b0);
        chk(!col_valid, "R8", col_valid, 0);
        @(negedge clk);
        chk(!col_valid, "R8", col_valid, 0);
        mode_ba = 2'b00;
        kick(8'h20, mk_mode(5, 1'b0, 2, 1'b0), 1'b0, 1'b0);
        chk(!col_valid, "R8", col_valid, 0);
    endtask

    task automatic t_restart;
        kick(8'h10, mk_mode(3, 1'b0, 2, 1'b0), 1'b0, 1'b0);
        chk(col == 8'h10, "R9", col, 8'h10);
        @(negedge clk);
        chk(col == 8'h11, "R9", col, 8'h11);
        start_col = 8'h27;
        mode_a = mk_mode(3, 1'b1, 2, 1'b0);
        start = 1'b1;
        abort = 1'b1;
        @(negedge clk);
        start = 1'b0;
        abort = 1'b0;
        chk(col_valid && col == 8'h27 && !col_last, "R9", col, 8'h27);
        @(negedge clk);
        follow("R9", 8'h27, 8, 1'b1, 1);
    endtask

    task automatic t_abort;
        kick(8'h60, mk_mode(3, 1'b0, 2, 1'b0), 1'b0, 1'b0);
        @(negedge clk);
        chk(col_valid && col == 8'h61, "R10", col, 8'h61);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!col_valid, "R10", col_valid, 0);
        @(negedge clk);
        chk(!col_valid, "R10", col_valid, 0);
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_single_write();
        t_mode_err();
        t_restart();
        t_abort();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule